// File: doc/BRIEF.md
# Common Pedestal Estimator and Subtractor

This block sits after the channel parser of a front-end readout chain. It receives a stream of parsed samples, each carrying a valid qualifier and a channel number. It removes a single baseline offset, the pedestal, that is shared by every channel of the chip. The pedestal comes from one of two places. In automatic mode it is a value measured from the stream itself: a calibration request averages the next 2^CAL_LOG2 valid samples (1024 by default, eight full 128-channel frames). In manual mode it is a value presented on a dedicated input.

Subtraction can be switched off, in which case samples pass through untouched. The datapath accepts one sample per clock and delivers it a fixed number of cycles later, with its valid flag and channel number aligned to it. A negative difference is clamped at zero, so the output keeps the input width. A calibration runs in the background. Until it completes, the previously measured pedestal stays in use.

Top module: `pedestal_trim`

## Requirements
- R1: After reset, `out_valid`, `cal_busy` and `cal_done` are 0, `out_data` and `out_chan` are 0, and the automatic pedestal is 0.
- R2: When `sub_enable` is 0, a valid sample leaves with `out_data` equal to `in_data`, whatever the pedestal source and value.
- R3: When `sub_enable` is 1, `out_data` = `in_data` − P. P is `manual_ped` when `use_manual` is 1, and the stored automatic pedestal when `use_manual` is 0. The inputs are sampled in the same cycle as the sample.
- R4: When `sub_enable` is 1 and `in_data` < P, `out_data` is 0.
- R5: `out_valid` and `out_chan` follow `in_valid` and `in_chan` exactly LATENCY clock edges later (default 2). Back-to-back samples leave in consecutive cycles.
- R6: While `out_valid` is 0, `out_data` and `out_chan` keep the values of the last valid output.
- R7: A `cal_start` pulse while `cal_busy` is 0 sets `cal_busy` and clears `cal_done` at the next edge. The next 2^CAL_LOG2 cycles with `in_valid` = 1 are then summed. Cycles with `in_valid` = 0 are not counted. Samples in the start cycle itself are not counted.
- R8: At the edge that accepts the last counted sample, `cal_busy` falls, `cal_done` rises, and the automatic pedestal becomes floor(sum / 2^CAL_LOG2). `cal_start` while `cal_busy` is 1 is ignored and does not restart the count.
- R9: During a calibration, subtraction in automatic mode keeps using the pedestal stored before the calibration began.
- R10: The manual value never alters the stored automatic pedestal. Returning `use_manual` to 0 restores subtraction by the last measured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_chan | input | CHAN_W (7) | Channel number of the input sample |
| in_data | input | DATA_W (12) | Parsed input sample |
| cal_start | input | 1 | Request a pedestal measurement |
| use_manual | input | 1 | 1: subtract `manual_ped`; 0: subtract the measured pedestal |
| manual_ped | input | DATA_W (12) | Pedestal value for manual mode |
| sub_enable | input | 1 | 1: subtract the pedestal; 0: pass data unchanged |
| out_valid | output | 1 | Output sample qualifier |
| out_chan | output | CHAN_W (7) | Channel number aligned with `out_data` |
| out_data | output | DATA_W (12) | Pedestal-corrected sample |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | The last calibration has completed |

## Verification
The hardest situation to reach from the ports is the end of a long calibration that has been disturbed in two ways. Idle gaps appear between counted samples, and a second start request arrives part way through. Either fault would show only as a shifted completion cycle or a wrong mean. The bench therefore feeds exactly 1024 valid samples of two alternating values with an idle cycle inserted every seventh sample, and pulses the start request at sample 500. It checks that the busy flag is still set just before the last sample, that the flags flip right after it, and that the rounded-down mean then appears in the corrected data. A second calibration, run with subtraction active, shows that the old pedestal stays in force until the new one lands.

// File: rtl/pedtrim_pkg.sv
package pedtrim_pkg;

   typedef enum logic {
      CAL_IDLE = 1'b0,
      CAL_RUN  = 1'b1
   } cal_state_e;

endpackage

// File: rtl/pedtrim_accum.sv
module pedtrim_accum
   import pedtrim_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int CAL_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] ped_auto
);

   localparam int SUM_W = DATA_W + CAL_LOG2;
   localparam logic [CAL_LOG2-1:0] CNT_LAST = '1;

   cal_state_e          state_q;
   logic [SUM_W-1:0]    sum_q;
   logic [SUM_W-1:0]    sum_nx;
   logic [CAL_LOG2-1:0] cnt_q;

   assign sum_nx = sum_q + SUM_W'(smp_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= CAL_IDLE;
         sum_q    <= '0;
         cnt_q    <= '0;
         done     <= 1'b0;
         ped_auto <= '0;
      end else begin
         case (state_q)
            CAL_IDLE: begin
               if (start) begin
                  state_q <= CAL_RUN;
                  sum_q   <= '0;
                  cnt_q   <= '0;
                  done    <= 1'b0;
               end
            end
            CAL_RUN: begin
               if (smp_valid) begin
                  sum_q <= sum_nx;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_LAST) begin
                     state_q  <= CAL_IDLE;
                     done     <= 1'b1;
                     ped_auto <= sum_nx[SUM_W-1:CAL_LOG2];
                  end
               end
            end
            default: state_q <= CAL_IDLE;
         endcase
      end
   end

   assign busy = (state_q == CAL_RUN);

endmodule

// File: rtl/pedtrim_srcsel.sv
module pedtrim_srcsel #(
   parameter int DATA_W = 12
) (
   input  logic              use_manual,
   input  logic              sub_enable,
   input  logic [DATA_W-1:0] manual_ped,
   input  logic [DATA_W-1:0] ped_auto,
   output logic [DATA_W-1:0] ped_eff
);

   always_comb begin
      if (!sub_enable)
         ped_eff = '0;
      else if (use_manual)
         ped_eff = manual_ped;
      else
         ped_eff = ped_auto;
   end

endmodule

// File: rtl/pedtrim_sub.sv
module pedtrim_sub #(
   parameter int DATA_W  = 12,
   parameter int CHAN_W  = 7,
   parameter int LATENCY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] ped_eff,
   output logic              out_valid,
   output logic [CHAN_W-1:0] out_chan,
   output logic [DATA_W-1:0] out_data
);

   logic [DATA_W:0]   diff;
   logic [DATA_W-1:0] clamped;

   assign diff    = {1'b0, in_data} - {1'b0, ped_eff};
   assign clamped = diff[DATA_W] ? '0 : diff[DATA_W-1:0];

   logic              v_q [LATENCY];
   logic [CHAN_W-1:0] c_q [LATENCY];
   logic [DATA_W-1:0] d_q [LATENCY];

   for (genvar s = 0; s < LATENCY; s++) begin : g_stage
      logic              vin;
      logic [CHAN_W-1:0] cin;
      logic [DATA_W-1:0] din;
      if (s == 0) begin : g_head
         assign vin = in_valid;
         assign cin = in_chan;
         assign din = clamped;
      end else begin : g_tail
         assign vin = v_q[s-1];
         assign cin = c_q[s-1];
         assign din = d_q[s-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q[s] <= 1'b0;
            c_q[s] <= '0;
            d_q[s] <= '0;
         end else begin
            v_q[s] <= vin;
            if (vin) begin
               c_q[s] <= cin;
               d_q[s] <= din;
            end
         end
      end
   end

   assign out_valid = v_q[LATENCY-1];
   assign out_chan  = c_q[LATENCY-1];
   assign out_data  = d_q[LATENCY-1];

endmodule

// File: rtl/pedestal_trim.sv
module pedestal_trim #(
   parameter int DATA_W   = 12,
   parameter int CHAN_W   = 7,
   parameter int CAL_LOG2 = 10,
   parameter int LATENCY  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cal_start,
   input  logic              use_manual,
   input  logic [DATA_W-1:0] manual_ped,
   input  logic              sub_enable,
   output logic              out_valid,
   output logic [CHAN_W-1:0] out_chan,
   output logic [DATA_W-1:0] out_data,
   output logic              cal_busy,
   output logic              cal_done
);

   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data_w
      $error("pedestal_trim: DATA_W out of range");
   end
   if (CHAN_W < 1) begin : g_bad_chan_w
      $error("pedestal_trim: CHAN_W must be at least 1");
   end
   if (CAL_LOG2 < 1 || CAL_LOG2 > 24) begin : g_bad_cal
      $error("pedestal_trim: CAL_LOG2 out of range");
   end
   if (LATENCY < 1 || LATENCY > 8) begin : g_bad_lat
      $error("pedestal_trim: LATENCY out of range");
   end

   logic [DATA_W-1:0] ped_auto;
   logic [DATA_W-1:0] ped_eff;

   pedtrim_accum #(
      .DATA_W  (DATA_W),
      .CAL_LOG2(CAL_LOG2)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cal_start),
      .smp_valid(in_valid),
      .smp_data (in_data),
      .busy     (cal_busy),
      .done     (cal_done),
      .ped_auto (ped_auto)
   );

   pedtrim_srcsel #(
      .DATA_W(DATA_W)
   ) u_srcsel (
      .use_manual(use_manual),
      .sub_enable(sub_enable),
      .manual_ped(manual_ped),
      .ped_auto  (ped_auto),
      .ped_eff   (ped_eff)
   );

   pedtrim_sub #(
      .DATA_W (DATA_W),
      .CHAN_W (CHAN_W),
      .LATENCY(LATENCY)
   ) u_sub (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_chan  (in_chan),
      .in_data  (in_data),
      .ped_eff  (ped_eff),
      .out_valid(out_valid),
      .out_chan (out_chan),
      .out_data (out_data)
   );

endmodule

// File: rtl/pedtrim_chk.sv
module pedtrim_chk #(
   parameter int DATA_W  = 12,
   parameter int LATENCY = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              cal_start,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              cal_busy,
   input logic              cal_done,
   input logic [DATA_W-1:0] ped_auto
);

   logic [LATENCY-1:0] vsh;

   always_ff @(posedge clk) begin
      if (!rst_n) vsh <= '0;
      else        vsh <= (vsh << 1) | LATENCY'(in_valid);
   end

   AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vsh[LATENCY-1]);                                 // R5

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));                            // R6

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_start && !cal_busy) |=> (cal_busy && !cal_done));        // R7

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_busy && cal_done));                                     // R8

   AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_done) |-> $fell(cal_busy));                         // R8

   AST_PED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> $stable(ped_auto));                              // R9

endmodule

bind pedestal_trim pedtrim_chk #(
   .DATA_W (DATA_W),
   .LATENCY(LATENCY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .cal_start(cal_start),
   .out_valid(out_valid),
   .out_data (out_data),
   .cal_busy (cal_busy),
   .cal_done (cal_done),
   .ped_auto (ped_auto)
);

// File: tb/pedestal_trim_test.sv
`timescale 1ns/1ps
module pedestal_trim_test;

   localparam int DW  = 12;
   localparam int CW  = 7;
   localparam int LAT = 2;
   localparam int NCAL = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [CW-1:0] in_chan = '0;
   logic [DW-1:0] in_data = '0;
   logic          cal_start = 1'b0;
   logic          use_manual = 1'b0;
   logic [DW-1:0] manual_ped = '0;
   logic          sub_enable = 1'b0;
   logic          out_valid;
   logic [CW-1:0] out_chan;
   logic [DW-1:0] out_data;
   logic          cal_busy;
   logic          cal_done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pedestal_trim uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_data(in_data), .cal_start(cal_start), .use_manual(use_manual),
      .manual_ped(manual_ped), .sub_enable(sub_enable), .out_valid(out_valid),
      .out_chan(out_chan), .out_data(out_data), .cal_busy(cal_busy),
      .cal_done(cal_done)
   );

   // {manual pedestal, enable, input, expected output}
   localparam int NV = 9;
   localparam logic [36:0] VEC [NV] = '{
      {12'd100,  1'b1, 12'd500,  12'd400 },
      {12'd100,  1'b0, 12'd500,  12'd500 },
      {12'd0,    1'b1, 12'd4095, 12'd4095},
      {12'd4095, 1'b1, 12'd4095, 12'd0   },
      {12'd300,  1'b1, 12'd299,  12'd0   },
      {12'd300,  1'b1, 12'd300,  12'd0   },
      {12'd1,    1'b1, 12'd0,    12'd0   },
      {12'd4095, 1'b0, 12'd17,   12'd17  },
      {12'd2048, 1'b1, 12'd3000, 12'd952 }
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_and_check(input int d, input int ch, input int exp, input string req);
      in_valid = 1'b1;
      in_data  = DW'(d);
      in_chan  = CW'(ch);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '1;
      repeat (LAT - 1) @(negedge clk);
      check({req, " valid"}, int'(out_valid), 1);
      check({req, " data"}, int'(out_data), exp);
      check({req, " chan"}, int'(out_chan), ch);
      @(negedge clk);
      check("R6 idle valid", int'(out_valid), 0);
      check("R6 hold data", int'(out_data), exp);
   endtask

   task automatic run_cal(input int lo, input int hi, input int old_ped);
      int gap;
      gap = 0;
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      check("R7 busy after start", int'(cal_busy), 1);
      check("R7 done cleared", int'(cal_done), 0);
      for (int i = 0; i < NCAL; i++) begin
         int smp;
         smp = (i % 2 == 1) ? hi : lo;
         if (i < 4) begin
            // R9: old pedestal still applied while measuring
            send_and_check(smp, i, (smp > old_ped) ? smp - old_ped : 0, "R9 old ped in use");
         end else begin
            if (i == NCAL - 1) begin
               check("R8 busy before last", int'(cal_busy), 1);
               check("R8 done before last", int'(cal_done), 0);
            end
            gap++;
            if (gap == 7) begin
               gap = 0;
               in_valid = 1'b0;
               in_data  = '1;
               @(negedge clk);
            end
            in_valid  = 1'b1;
            in_data   = DW'(smp);
            in_chan   = CW'(i);
            cal_start = (i == 500);
            @(negedge clk);
            cal_start = 1'b0;
         end
      end
      in_valid = 1'b0;
      check("R8 busy after last", int'(cal_busy), 0);
      check("R8 done after last", int'(cal_done), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", int'(out_valid), 0);
      check("R1 reset busy", int'(cal_busy), 0);
      check("R1 reset done", int'(cal_done), 0);
      check("R1 reset data", int'(out_data), 0);
      check("R1 reset chan", int'(out_chan), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: stored automatic pedestal starts at zero
      sub_enable = 1'b1;
      use_manual = 1'b0;
      send_and_check(777, 5, 777, "R1 auto ped zero");

      // R2 R3 R4: vector table in manual mode
      use_manual = 1'b1;
      for (int v = 0; v < NV; v++) begin
         manual_ped = VEC[v][36:25];
         sub_enable = VEC[v][24];
         send_and_check(int'(VEC[v][23:12]), (v * 13) % 128, int'(VEC[v][11:0]), "R3 table");
      end

      // R5: back-to-back samples, one per cycle
      sub_enable = 1'b0;
      for (int k = 0; k < 3 + LAT; k++) begin
         if (k >= LAT) begin
            check("R5 stream valid", int'(out_valid), 1);
            check("R5 stream data", int'(out_data), 1000 + k - LAT);
            check("R5 stream chan", int'(out_chan), 40 + k - LAT);
         end
         if (k < 3) begin
            in_valid = 1'b1;
            in_data  = DW'(1000 + k);
            in_chan  = CW'(40 + k);
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      check("R5 stream end", int'(out_valid), 0);

      // R7 R8: first calibration, mean of 100/103 -> 101
      sub_enable = 1'b1;
      use_manual = 1'b0;
      run_cal(100, 103, 0);
      send_and_check(500, 9, 399, "R8 new auto ped");

      // R9: second calibration, mean of 200/201 -> 200
      run_cal(200, 201, 101);
      send_and_check(150, 10, 0, "R4 clamp auto");
      send_and_check(260, 11, 60, "R8 second ped");

      // R10: manual value leaves the stored pedestal alone
      use_manual = 1'b1;
      manual_ped = 12'd30;
      send_and_check(80, 12, 50, "R10 manual");
      use_manual = 1'b0;
      send_and_check(250, 13, 50, "R10 auto restored");

      // R2: bypass ignores the stored pedestal
      sub_enable = 1'b0;
      send_and_check(123, 14, 123, "R2 bypass auto");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule